// File: doc/BRIEF.md
# Per-Output Clock Gate with Power-Down

This block gates one reference clock onto eight output pairs. Each pair carries a true leg, which follows the high phases of the reference, and a complement leg, which follows its low phases. A pair runs only when two enable sources agree. The first is a hardware pin that is active low. The second is a software bit that is active high and is normally held at 1 by a register outside the block. A separate active-low power-down input can stop every pair at once, whatever the enables say.

The enable inputs may change at any moment. Each one passes through a chain of `SYNC_STAGES` flops clocked on the rising edge. The true-leg gate then changes only on a falling edge, and the complement-leg gate changes only on a rising edge. As a result, every pulse on either leg is a full half period and no runt pulse is ever produced. The power-down input is sampled on falling edges of the reference, which are the rising edges of the complement clock. It must be seen low on two consecutive samples before it takes effect.

Top module: `clk_gate_fanout`

## Requirements
- R1: While `rst_n` is low, every bit of `out_p` and `out_n` is 0.
- R2: Output i runs when `oe_n[i]` is 0 and `sw_en[i]` is 1. It stays off when `oe_n[i]` is 1, and it is forced off when `sw_en[i]` is 0, whatever its pin shows. While output i runs, `out_p[i]` is high in every high phase of `clk_ref`.
- R3: While output i is off, both `out_p[i]` and `out_n[i]` are held at 0.
- R4: After the enable condition of an output becomes true, the output starts within 4 to 8 periods. The start is taken as the first rising edge of `clk_ref` at which `out_p[i]` rises. With the default `SYNC_STAGES` of 4, this is the fifth rising edge after the change.
- R5: After the enable condition of an output becomes false, the output stops within 4 to 8 periods. The stop is taken as the first rising edge of `clk_ref` at which `out_p[i]` no longer rises.
- R6: Every high pulse on any bit of `out_p` or `out_n` lasts exactly one half period of `clk_ref`.
- R7: A low level on `pwr_n` that is caught by only one falling edge of `clk_ref` has no effect on the outputs.
- R8: Power-down takes effect once `pwr_n` has been sampled low on two consecutive falling edges of `clk_ref`. At the next rising edge, every complement leg stops. Every true leg finishes the high phase that begins at that edge and then stays low. After that, all outputs remain off whatever `oe_n` and `sw_en` show.
- R9: When `pwr_n` has been sampled high on two consecutive falling edges, the block leaves power-down, and the outputs that are enabled run again.
- R10: `out_n[i]` pulses only in the low phase that directly follows a high phase in which `out_p[i]` pulsed. When an output stops, its complement leg gives one last low-phase pulse after the last true pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock that is gated onto all outputs |
| rst_n | input | 1 | Asynchronous reset, active low |
| oe_n | input | N_OUT | Per-output hardware enable pins, active low, asynchronous |
| sw_en | input | N_OUT | Per-output software enable bits, active high |
| pwr_n | input | 1 | Power-down request, active low, asynchronous |
| out_p | output | N_OUT | True leg of each output pair |
| out_n | output | N_OUT | Complement leg of each output pair |

## Verification
A behavioural reference model is compared with both legs in every high phase and every low phase. The enables are driven with several patterns: all outputs on, alternating pin patterns, and patterns where the software bits and the pins disagree. These patterns show whether each source is honoured separately and whether the two polarities are combined correctly. Start and stop latencies are measured in real time, from enable changes placed just after a rising edge and just before one, which are the two extremes of the synchronizer window. Power-down is tried in two ways. A low pulse caught by one sample must be ignored, while a held low must stop all outputs. A width monitor on every leg catches any runt or zero-width pulse.

// File: rtl/clk_gate_fanout.sv
`timescale 1ns/1ps
module clk_gate_fanout #(
  parameter int N_OUT       = 8,
  parameter int SYNC_STAGES = 4
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [N_OUT-1:0] oe_n,
  input  logic [N_OUT-1:0] sw_en,
  input  logic             pwr_n,
  output logic [N_OUT-1:0] out_p,
  output logic [N_OUT-1:0] out_n
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [N_OUT-1:0] req;
  logic [N_OUT-1:0] sync_q [SYNC_STAGES];
  logic [1:0]       pd_smp;
  logic             run_pwr, pwr_next;
  logic [N_OUT-1:0] en_p, en_n;

  assign req = ~oe_n & sw_en;

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      for (int j = 0; j < SYNC_STAGES; j++) sync_q[j] <= '0;
    end else begin
      sync_q[0] <= req;
      for (int j = 1; j < SYNC_STAGES; j++) sync_q[j] <= sync_q[j-1];
    end

  always_ff @(negedge clk_ref or negedge rst_n)
    if (!rst_n) pd_smp <= 2'b00;
    else        pd_smp <= {pd_smp[0], pwr_n};

  always_comb begin
    pwr_next = run_pwr;
    if (pd_smp == 2'b00)      pwr_next = 1'b0;
    else if (pd_smp == 2'b11) pwr_next = 1'b1;
  end

  always_ff @(posedge clk_ref or negedge rst_n)
    if (!rst_n) begin
      run_pwr <= 1'b0;
      en_n    <= '0;
    end else begin
      run_pwr <= pwr_next;
      en_n    <= en_p & {N_OUT{pwr_next}};
    end

  always_ff @(negedge clk_ref or negedge rst_n)
    if (!rst_n) en_p <= '0;
    else        en_p <= sync_q[LAST] & {N_OUT{run_pwr}};

  assign out_p = en_p & {N_OUT{clk_ref}};
  assign out_n = en_n & {N_OUT{~clk_ref}};
endmodule

// File: rtl/clk_gate_fanout_chk.sv
`timescale 1ns/1ps
module clk_gate_fanout_chk #(
  parameter int N_OUT = 8
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic             pwr_n,
  input logic [N_OUT-1:0] out_p,
  input logic [N_OUT-1:0] out_n,
  input logic [N_OUT-1:0] en_p
);
  logic [1:0] seen;
  logic       low2;

  always_ff @(negedge clk_ref or negedge rst_n)
    if (!rst_n) seen <= 2'b11;
    else        seen <= {seen[0], pwr_n};

  assign low2 = ~seen[0] & ~seen[1];

  always_comb
    if (!rst_n) p_quiet_in_reset_r1: assert (out_p == '0 && out_n == '0);

  p_comp_stops_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    low2 |=> out_n == '0);

  p_true_stops_r8: assert property (@(negedge clk_ref) disable iff (!rst_n)
    low2 |=> out_p == '0);

  p_comp_after_true_r10: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (out_n & ~$past(en_p)) == '0);
endmodule

bind clk_gate_fanout clk_gate_fanout_chk #(.N_OUT(N_OUT)) u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .pwr_n(pwr_n),
  .out_p(out_p), .out_n(out_n), .en_p(en_p)
);

// File: tb/clk_gate_fanout_tb.sv
`timescale 1ns/1ps
module clk_gate_fanout_tb;
  localparam int  N = 8;
  localparam int  S = 4;
  localparam real T = 4.0;

  logic         clk = 1'b0, rst_n = 1'b0, pwr_n = 1'b1;
  logic [N-1:0] oe_n = '1, sw_en = '1;
  logic [N-1:0] out_p, out_n;
  int           n_chk = 0, n_bad = 0;
  string        tag = "R1";

  clk_gate_fanout #(.N_OUT(N), .SYNC_STAGES(S)) u_dut (
    .clk_ref(clk), .rst_n(rst_n), .oe_n(oe_n), .sw_en(sw_en),
    .pwr_n(pwr_n), .out_p(out_p), .out_n(out_n)
  );

  always #(T/2) clk = ~clk;

  task automatic check(input bit ok, input string t, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: got %s expected %s", t, $realtime, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // reference model, compared in every phase
  logic [N-1:0] q[$];
  bit           run_m = 0, pn1 = 0, pn2 = 0, old_run = 0;
  logic [N-1:0] pe = '0, ne = '0;
  initial forever begin
    @(posedge clk);
    if (!rst_n) begin
      q.delete(); run_m = 0; pn1 = 0; pn2 = 0; pe = '0; ne = '0;
    end else begin
      old_run = run_m;
      if (!pn1 && !pn2) run_m = 0;
      else if (pn1 && pn2) run_m = 1;
      q.push_back(~oe_n & sw_en);
      pe = '0;
      if (q.size() > S) begin
        pe = q.pop_front();
        if (!old_run) pe = '0;
      end
      ne = run_m ? pe : '0;
    end
    #1;
    check(out_p === pe && out_n === '0, $sformatf("%s true leg", tag),
          $sformatf("p=%h n=%h", out_p, out_n), $sformatf("p=%h n=00", pe));
    @(negedge clk);
    if (rst_n) begin pn2 = pn1; pn1 = pwr_n; end
    #1;
    check(out_n === ne && out_p === '0, $sformatf("%s R10 complement leg", tag),
          $sformatf("p=%h n=%h", out_p, out_n), $sformatf("p=00 n=%h", ne));
  end

  // pulse width monitor
  real          rp[N], rn[N];
  logic [N-1:0] pp = '0, pq = '0;
  always @(out_p or out_n) begin
    for (int i = 0; i < N; i++) begin
      if (out_p[i] !== pp[i]) begin
        if (out_p[i]) rp[i] = $realtime;
        else check(($realtime - rp[i]) > T/2 - 0.001 && ($realtime - rp[i]) < T/2 + 0.001,
                   "R6 true pulse width", $sformatf("%0.3f ns", $realtime - rp[i]), "2.000 ns");
      end
      if (out_n[i] !== pq[i]) begin
        if (out_n[i]) rn[i] = $realtime;
        else check(($realtime - rn[i]) > T/2 - 0.001 && ($realtime - rn[i]) < T/2 + 0.001,
                   "R6 complement pulse width", $sformatf("%0.3f ns", $realtime - rn[i]), "2.000 ns");
      end
    end
    pp = out_p;
    pq = out_n;
  end

  task automatic at_hi;
    @(posedge clk); #1.5;
  endtask

  task automatic at_lo;
    @(negedge clk); #1.5;
  endtask

  task automatic latency(input int b, input bit on, input real off);
    real t0, lc;
    int  k;
    @(posedge clk); #(off);
    oe_n[b] = on ? 1'b0 : 1'b1;
    t0 = $realtime;
    k = 0;
    do begin @(posedge clk); #0.5; k++; end while (out_p[b] !== on && k < 20);
    lc = ($realtime - 0.5 - t0) / T;
    check(lc >= 4.0 && lc <= 8.0, on ? "R4 start latency" : "R5 stop latency",
          $sformatf("%0.2f cycles", lc), "4..8 cycles");
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (2) at_hi;
    check(out_p == '0 && out_n == '0, "R1 reset high phase", $sformatf("%h/%h", out_p, out_n), "00/00");
    at_lo;
    check(out_p == '0 && out_n == '0, "R1 reset low phase", $sformatf("%h/%h", out_p, out_n), "00/00");
    @(negedge clk); #1.3 rst_n = 1'b1;
    tag = "R3";
    repeat (4) at_hi;
    check(out_p == '0, "R3 pins high", $sformatf("%h", out_p), "00");

    tag = "R2";
    oe_n = 8'h00;
    repeat (8) at_hi;
    check(out_p == 8'hFF, "R2 all enabled", $sformatf("%h", out_p), "ff");
    at_lo;
    check(out_n == 8'hFF, "R10 complement all enabled", $sformatf("%h", out_n), "ff");
    oe_n = 8'hA5;
    repeat (8) at_hi;
    check(out_p == 8'h5A, "R2 pin pattern", $sformatf("%h", out_p), "5a");
    at_lo;
    check((out_n & 8'hA5) == '0, "R3 disabled complement low", $sformatf("%h", out_n & 8'hA5), "00");
    oe_n = 8'h00; sw_en = 8'h0F;
    repeat (8) at_hi;
    check(out_p == 8'h0F, "R2 software override", $sformatf("%h", out_p), "0f");
    oe_n = 8'h3C; sw_en = 8'hF0;
    repeat (8) at_hi;
    check(out_p == 8'hC0, "R2 both sources", $sformatf("%h", out_p), "c0");
    oe_n = 8'hFF; sw_en = 8'hFF;
    repeat (8) at_hi;
    check(out_p == '0, "R3 all disabled", $sformatf("%h", out_p), "00");

    tag = "R4";
    latency(2, 1'b1, 0.3);
    tag = "R5";
    latency(2, 1'b0, 0.3);
    tag = "R4";
    latency(6, 1'b1, 3.7);
    tag = "R5";
    latency(6, 1'b0, 3.7);

    tag = "R7";
    oe_n = 8'h00;
    repeat (8) at_hi;
    @(negedge clk); #0.5 pwr_n = 1'b0;
    @(negedge clk); #0.5 pwr_n = 1'b1;
    repeat (6) begin
      at_hi;
      check(out_p == 8'hFF, "R7 single low sample ignored", $sformatf("%h", out_p), "ff");
    end

    tag = "R8";
    @(negedge clk); #0.5 pwr_n = 1'b0;
    repeat (5) at_hi;
    check(out_p == '0, "R8 true legs off", $sformatf("%h", out_p), "00");
    at_lo;
    check(out_n == '0, "R8 complement legs off", $sformatf("%h", out_n), "00");
    oe_n = 8'hF0; sw_en = 8'h55;
    repeat (8) at_hi;
    oe_n = 8'h00; sw_en = 8'hFF;
    repeat (8) at_hi;
    check(out_p == '0 && out_n == '0, "R8 enables ignored in power-down",
          $sformatf("%h/%h", out_p, out_n), "00/00");

    tag = "R9";
    pwr_n = 1'b1;
    repeat (6) at_hi;
    check(out_p == 8'hFF, "R9 resume after power-down", $sformatf("%h", out_p), "ff");
    at_lo;
    check(out_n == 8'hFF, "R10 complement resumes", $sformatf("%h", out_n), "ff");
    repeat (4) at_hi;
    report();
  end

  initial begin
    #50000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    report();
  end
endmodule